// File: doc/BRIEF.md
# Dual-Mode Serial Frame Receiver

This block turns an asynchronous serial line into parallel words. It supports two line codes. In level (NRZ) coding each bit holds one level for a whole bit time. In Manchester bi-phase coding each bit is sent as two opposite half-bit levels, and the direction of the edge at the centre of the bit gives its value. The line is oversampled under an external sample tick. A frame begins with a start bit that is low for a full bit time in both codes. Next come a configurable number of data bits, least-significant first. In level coding an optional parity bit follows the data. The frame ends with one or two stop bits.

The encoding, data length, parity mode and stop count are latched when a start edge is detected. When a frame completes, the receiver updates a registered result bank and pulses a one-clock valid strobe. The bank holds the data word, the parity, framing and code-violation flags, and the stop-bit values. Manchester frames carry no parity bit and keep both stop-bit values. Level frames wait through a second stop bit but neither check nor keep it.

Top module: `dual_line_rx`

## Requirements
- R1: In level mode the word is assembled least-significant bit first from `cfg_nbits` data bits (1 to DATA_W). Bits of `rx_data` at and above `cfg_nbits` read 0.
- R2: In level mode, with OSR=16 samples numbered 0..15 from the first low sample of the start bit, each bit value is the majority of samples 7, 8 and 9. A single disturbed sample at the centre does not change the result.
- R3: `cfg_parity` encodings: 2'b00 and 2'b01 mean no parity bit, 2'b10 even, 2'b11 odd. In level mode with parity enabled, the bit after the last data bit is compared with the XOR of the data bits, inverted for odd. A mismatch sets `rx_perr`. Without parity, `rx_perr` is 0.
- R4: In Manchester mode a low-to-high centre transition decodes as 1 and a high-to-low transition decodes as 0.
- R5: In Manchester mode no parity bit is consumed and `rx_perr` is 0 whatever `cfg_parity` holds.
- R6: In Manchester mode with `cfg_two_stop`=1, `rx_stop[0]` holds the first stop value and `rx_stop[1]` holds the second. With one stop bit, `rx_stop[1]` is 0.
- R7: In level mode with two stop bits, the receiver waits out the second stop bit, but its value affects no flag and `rx_stop[1]` is 0.
- R8: `rx_ferr` is 1 exactly when the first stop bit decodes as 0, in either mode.
- R9: In Manchester mode a bit whose two half-bit votes are equal sets `rx_cverr` for that frame. The bit decodes as its second-half value. In level mode `rx_cverr` is always 0.
- R10: A falling edge whose start bit is not low at its centre vote is dropped with no valid strobe.
- R11: After reset all outputs are 0. `rx_valid` is a single-clock pulse at frame end, and the result outputs change only in that cycle.
- R12: The sampler advances only on cycles with `sample_tick`=1, so results do not depend on the tick rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_tick | input | 1 | Oversampling enable, OSR ticks per bit |
| line_in | input | 1 | Serial line, idle high |
| cfg_manch | input | 1 | 1 selects Manchester, 0 selects level coding |
| cfg_nbits | input | $clog2(DATA_W+1) | Data bits per frame |
| cfg_parity | input | 2 | Parity mode (see R3) |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| rx_data | output | DATA_W | Received word, LSB first on the line |
| rx_valid | output | 1 | One-clock frame-complete strobe |
| rx_perr | output | 1 | Parity mismatch |
| rx_ferr | output | 1 | First stop bit was 0 |
| rx_cverr | output | 1 | Manchester code violation in the frame |
| rx_stop | output | 2 | Decoded stop values, first in bit 0 |

## Verification
The hardest conditions to reach from the pins are sample-level faults. One is a Manchester bit that has no centre transition. Another is a level bit with a single corrupted sample exactly at its centre. A third is a start glitch that is too short to survive the centre vote. The bench builds every frame as a sequence of held levels measured in sample ticks. This lets it drop a one-sample pulse onto sample 8, or hold a Manchester bit at one level for both halves. A behavioural model queues the expected result of each frame, and the bench checks every clock for stray strobes and unstable outputs. One frame runs at a tick rate of one in three to confirm rate independence.

// File: rtl/dlr_pkg.sv
package dlr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP1,
    ST_STOP2
  } dlr_state_e;

  // majority of three samples
  function automatic logic maj3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction

endpackage

// File: rtl/dlr_sampler.sv
// Line synchronizer plus a three-sample history advanced on each tick.
module dlr_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       rxd,
  output logic [2:0] trio,   // {oldest, middle, current}
  output logic       fall    // high-to-low seen on this tick
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [1:0]             hist_q;
  logic                   line;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
  end

  assign line = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst)       hist_q <= '1;
    else if (tick) hist_q <= {hist_q[0], line};
  end

  assign trio = {hist_q, line};
  assign fall = tick & hist_q[0] & ~line;

endmodule

// File: rtl/dlr_framer.sv
// Frame sequencer: start validation, bit decode in both codes, result bank.
module dlr_framer
  import dlr_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8,
  parameter int NB_W   = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [2:0]        trio,
  input  logic              fall,
  input  logic              cfg_manch,
  input  logic [NB_W-1:0]   cfg_nbits,
  input  logic [1:0]        cfg_parity,
  input  logic              cfg_two_stop,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              out_perr,
  output logic              out_ferr,
  output logic              out_cverr,
  output logic [1:0]        out_stop
);

  localparam int CNT_W = $clog2(OSR);
  localparam int Q1    = OSR / 4 + 1;       // first-half vote complete
  localparam int MIDV  = OSR / 2 + 1;       // centre vote complete
  localparam int Q3    = 3 * OSR / 4 + 1;   // second-half vote complete
  localparam int LAST  = OSR - 1;           // bit end

  dlr_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [NB_W-1:0]   bit_idx;
  logic              lat_manch, lat_two;
  logic [NB_W-1:0]   lat_nbits;
  logic [1:0]        lat_par;
  logic [DATA_W-1:0] work_data;
  logic              par_acc, cv_acc, perr_w, ferr_w, stop0_w;
  logic              half_a, half_b, lvl_s;
  logic              vote, bit_v, viol;

  assign vote  = maj3(trio);
  assign bit_v = lat_manch ? half_b : lvl_s;
  assign viol  = lat_manch & (half_a == half_b);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      bit_idx   <= '0;
      lat_manch <= 1'b0;
      lat_two   <= 1'b0;
      lat_nbits <= '0;
      lat_par   <= '0;
      work_data <= '0;
      par_acc   <= 1'b0;
      cv_acc    <= 1'b0;
      perr_w    <= 1'b0;
      ferr_w    <= 1'b0;
      stop0_w   <= 1'b0;
      half_a    <= 1'b0;
      half_b    <= 1'b0;
      lvl_s     <= 1'b0;
      out_data  <= '0;
      out_valid <= 1'b0;
      out_perr  <= 1'b0;
      out_ferr  <= 1'b0;
      out_cverr <= 1'b0;
      out_stop  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (tick) begin
        if (state == ST_IDLE) begin
          if (fall) begin
            state     <= ST_START;
            cnt       <= CNT_W'(1);
            lat_manch <= cfg_manch;
            lat_two   <= cfg_two_stop;
            lat_nbits <= cfg_nbits;
            lat_par   <= cfg_parity;
            work_data <= '0;
            par_acc   <= 1'b0;
            cv_acc    <= 1'b0;
            perr_w    <= 1'b0;
            ferr_w    <= 1'b0;
            stop0_w   <= 1'b0;
          end
        end else begin
          cnt <= (cnt == CNT_W'(LAST)) ? '0 : cnt + 1'b1;
          if (cnt == CNT_W'(Q1)) half_a <= vote;
          if (cnt == CNT_W'(Q3)) half_b <= vote;
          if (cnt == CNT_W'(MIDV)) begin
            lvl_s <= vote;
            if (state == ST_START && vote) state <= ST_IDLE;  // false start
          end
          if (cnt == CNT_W'(LAST)) begin
            case (state)
              ST_START: begin
                state   <= ST_DATA;
                bit_idx <= '0;
              end
              ST_DATA: begin
                for (int i = 0; i < DATA_W; i++)
                  if (bit_idx == NB_W'(i)) work_data[i] <= bit_v;
                par_acc <= par_acc ^ bit_v;
                cv_acc  <= cv_acc | viol;
                if (bit_idx == lat_nbits - NB_W'(1))
                  state <= (!lat_manch && lat_par[1]) ? ST_PAR : ST_STOP1;
                else
                  bit_idx <= bit_idx + 1'b1;
              end
              ST_PAR: begin
                perr_w <= bit_v ^ par_acc ^ lat_par[0];
                state  <= ST_STOP1;
              end
              ST_STOP1: begin
                if (lat_two) begin
                  stop0_w <= bit_v;
                  ferr_w  <= ~bit_v;
                  cv_acc  <= cv_acc | viol;
                  state   <= ST_STOP2;
                end else begin
                  out_data  <= work_data;
                  out_perr  <= perr_w;
                  out_ferr  <= ~bit_v;
                  out_cverr <= cv_acc | viol;
                  out_stop  <= {1'b0, bit_v};
                  out_valid <= 1'b1;
                  state     <= ST_IDLE;
                end
              end
              ST_STOP2: begin
                out_data  <= work_data;
                out_perr  <= perr_w;
                out_ferr  <= ferr_w;
                out_cverr <= cv_acc | viol;
                out_stop  <= {lat_manch & bit_v, stop0_w};
                out_valid <= 1'b1;
                state     <= ST_IDLE;
              end
              default: state <= ST_IDLE;
            endcase
          end
        end
      end
    end
  end

endmodule

// File: rtl/dual_line_rx.sv
module dual_line_rx #(
  parameter int OSR         = 16,   // multiple of 4, at least 12
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int NB_W       = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_tick,
  input  logic              line_in,
  input  logic              cfg_manch,
  input  logic [NB_W-1:0]   cfg_nbits,
  input  logic [1:0]        cfg_parity,
  input  logic              cfg_two_stop,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_perr,
  output logic              rx_ferr,
  output logic              rx_cverr,
  output logic [1:0]        rx_stop
);

  logic [2:0] trio;
  logic       fall;

  dlr_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk  (clk),
    .rst  (rst),
    .tick (sample_tick),
    .rxd  (line_in),
    .trio (trio),
    .fall (fall)
  );

  dlr_framer #(.OSR(OSR), .DATA_W(DATA_W), .NB_W(NB_W)) u_framer (
    .clk          (clk),
    .rst          (rst),
    .tick         (sample_tick),
    .trio         (trio),
    .fall         (fall),
    .cfg_manch    (cfg_manch),
    .cfg_nbits    (cfg_nbits),
    .cfg_parity   (cfg_parity),
    .cfg_two_stop (cfg_two_stop),
    .out_data     (rx_data),
    .out_valid    (rx_valid),
    .out_perr     (rx_perr),
    .out_ferr     (rx_ferr),
    .out_cverr    (rx_cverr),
    .out_stop     (rx_stop)
  );

endmodule

// File: rtl/dlr_checker.sv
module dlr_checker #(
  parameter int DATA_W = 8,
  parameter int NB_W   = $clog2(DATA_W + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_manch,
  input logic [NB_W-1:0]   cfg_nbits,
  input logic [1:0]        cfg_parity,
  input logic              cfg_two_stop,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_valid,
  input logic              rx_perr,
  input logic              rx_ferr,
  input logic              rx_cverr,
  input logic [1:0]        rx_stop
);

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  a_r11_hold_between: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |-> ($stable(rx_data) && $stable(rx_perr) && $stable(rx_ferr)
                   && $stable(rx_cverr) && $stable(rx_stop)));

  a_r1_upper_zero: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> ((rx_data >> cfg_nbits) == '0));

  a_r3_no_parity_no_err: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !cfg_parity[1]) |-> !rx_perr);

  a_r5_manch_no_perr: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && cfg_manch) |-> !rx_perr);

  a_r6_r7_second_stop: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !(cfg_manch && cfg_two_stop)) |-> !rx_stop[1]);

  a_r8_ferr_first_stop: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (rx_ferr == !rx_stop[0]));

  a_r9_level_no_cv: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !cfg_manch) |-> !rx_cverr);

endmodule

bind dual_line_rx dlr_checker #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_manch    (cfg_manch),
  .cfg_nbits    (cfg_nbits),
  .cfg_parity   (cfg_parity),
  .cfg_two_stop (cfg_two_stop),
  .rx_data      (rx_data),
  .rx_valid     (rx_valid),
  .rx_perr      (rx_perr),
  .rx_ferr      (rx_ferr),
  .rx_cverr     (rx_cverr),
  .rx_stop      (rx_stop)
);

// File: tb/dual_line_rx_tb.sv
`timescale 1ns/1ps
module dual_line_rx_tb;

  localparam int OSR    = 16;
  localparam int DATA_W = 8;
  localparam int NB_W   = $clog2(DATA_W + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sample_tick;
  logic line_in = 1'b1;
  logic cfg_manch = 1'b0;
  logic [NB_W-1:0] cfg_nbits = NB_W'(8);
  logic [1:0] cfg_parity = 2'b00;
  logic cfg_two_stop = 1'b0;
  logic [DATA_W-1:0] rx_data;
  logic rx_valid, rx_perr, rx_ferr, rx_cverr;
  logic [1:0] rx_stop;

  always #2 clk = ~clk;   // 250 MHz

  dual_line_rx #(.OSR(OSR), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst(rst), .sample_tick(sample_tick), .line_in(line_in),
    .cfg_manch(cfg_manch), .cfg_nbits(cfg_nbits), .cfg_parity(cfg_parity),
    .cfg_two_stop(cfg_two_stop), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_cverr(rx_cverr), .rx_stop(rx_stop)
  );

  // tick generator
  int div = 1;
  int div_cnt = 0;
  assign sample_tick = (div_cnt == 0);
  always @(negedge clk) div_cnt = (div_cnt >= div - 1) ? 0 : div_cnt + 1;

  typedef struct {
    logic [7:0] d;
    logic pe, fe, cv;
    logic [1:0] st;
    string tag;
  } exp_t;

  exp_t q[$];
  int vectors = 0;
  int errors  = 0;
  bit done_run = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [7:0] got, input logic [7:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // per-clock comparison against the queued model
  logic [7:0] p_d = '0;
  logic p_pe = 0, p_fe = 0, p_cv = 0;
  logic [1:0] p_st = '0;
  always @(negedge clk) begin
    if (!rst && !done_run) begin
      if (rx_valid) begin
        if (q.size() == 0) begin
          check(1'b0, "R10", "unexpected valid", 8'(rx_data), 8'h00);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(rx_data == e.d,   e.tag, "data",  rx_data, e.d);
          check(rx_perr == e.pe,  e.tag, "perr",  8'(rx_perr), 8'(e.pe));
          check(rx_ferr == e.fe,  e.tag, "ferr",  8'(rx_ferr), 8'(e.fe));
          check(rx_cverr == e.cv, e.tag, "cverr", 8'(rx_cverr), 8'(e.cv));
          check(rx_stop == e.st,  e.tag, "stop",  8'(rx_stop), 8'(e.st));
        end
      end else begin
        // R11: outputs held between strobes
        check({rx_data, rx_perr, rx_ferr, rx_cverr, rx_stop} ==
              {p_d, p_pe, p_fe, p_cv, p_st}, "R11", "hold", rx_data, p_d);
      end
      p_d = rx_data; p_pe = rx_perr; p_fe = rx_ferr; p_cv = rx_cverr; p_st = rx_stop;
    end
  end

  task automatic hold(input logic lvl, input int n);
    line_in = lvl;
    repeat (n * div) @(negedge clk);
  endtask

  task automatic drive_bit(input logic manch, input logic b, input logic viol,
                           input logic corrupt);
    if (manch) begin
      if (viol) hold(b, OSR);
      else begin hold(~b, OSR / 2); hold(b, OSR / 2); end
    end else if (corrupt) begin
      hold(b, OSR / 2); hold(~b, 1); hold(b, OSR / 2 - 1);
    end else begin
      hold(b, OSR);
    end
  endtask

  task automatic send_frame(input logic manch, input int nb, input logic [1:0] par,
                            input logic two, input logic [7:0] d, input logic pflip,
                            input logic s1, input logic s2, input logic [7:0] vmask,
                            input logic corrupt, input string tag);
    exp_t e;
    logic [7:0] m;
    logic pb;
    cfg_manch = manch; cfg_nbits = NB_W'(nb); cfg_parity = par; cfg_two_stop = two;
    m = 8'((9'd1 << nb) - 9'd1);
    pb = ^(d & m) ^ par[0] ^ pflip;
    e.d  = d & m;
    e.pe = !manch && par[1] && pflip;
    e.fe = !s1;
    e.cv = manch && ((vmask & m) != 0);
    e.st = {manch && two && s2, s1};
    e.tag = tag;
    q.push_back(e);
    hold(1'b1, 2 * OSR);
    hold(1'b0, OSR);
    for (int i = 0; i < nb; i++) drive_bit(manch, d[i], manch && vmask[i], corrupt);
    if (!manch && par[1]) drive_bit(1'b0, pb, 1'b0, 1'b0);
    drive_bit(manch, s1, 1'b0, 1'b0);
    if (two) drive_bit(manch, s2, 1'b0, 1'b0);
    hold(1'b1, 2 * OSR);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done_run) begin
      done_run = 1'b1;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check({rx_data, rx_valid, rx_perr, rx_ferr, rx_cverr, rx_stop} == '0,
          "R11", "reset", rx_data, 8'h00);

    // level mode
    send_frame(0, 8, 2'b00, 0, 8'hA5, 0, 1, 1, 8'h00, 0, "R1");
    send_frame(0, 5, 2'b00, 0, 8'hFB, 0, 1, 1, 8'h00, 0, "R1_short");
    send_frame(0, 8, 2'b10, 0, 8'h3C, 0, 1, 1, 8'h00, 0, "R3_even_ok");
    send_frame(0, 7, 2'b11, 0, 8'h52, 1, 1, 1, 8'h00, 0, "R3_odd_bad");
    send_frame(0, 8, 2'b11, 0, 8'h69, 0, 1, 1, 8'h00, 0, "R3_odd_ok");
    send_frame(0, 8, 2'b00, 0, 8'hC3, 0, 1, 1, 8'h00, 1, "R2_centre_glitch");
    send_frame(0, 8, 2'b00, 0, 8'h0F, 0, 0, 1, 8'h00, 0, "R8_level");
    send_frame(0, 8, 2'b00, 1, 8'h81, 0, 1, 0, 8'h00, 0, "R7_stop2_ignored");
    send_frame(0, 6, 2'b00, 0, 8'h2D, 0, 1, 1, 8'hFF, 0, "R9_level_none");

    // R10: short low pulse is dropped
    hold(1'b1, 2 * OSR);
    hold(1'b0, 3);
    hold(1'b1, 3 * OSR);
    check(q.size() == 0, "R10", "queue", 8'(q.size()), 8'h00);

    // Manchester mode
    send_frame(1, 8, 2'b10, 0, 8'h96, 0, 1, 1, 8'h00, 0, "R4_R5");
    send_frame(1, 6, 2'b11, 0, 8'h25, 0, 1, 1, 8'h00, 0, "R4_short");
    send_frame(1, 8, 2'b00, 1, 8'h5A, 0, 1, 0, 8'h00, 0, "R6_s10");
    send_frame(1, 8, 2'b00, 1, 8'hE7, 0, 0, 1, 8'h00, 0, "R6_R8_s01");
    send_frame(1, 8, 2'b00, 0, 8'h33, 0, 1, 1, 8'h08, 0, "R9_violation");
    send_frame(1, 8, 2'b00, 0, 8'hCC, 0, 1, 1, 8'h00, 0, "R9_clean");

    // R12: slower tick rate
    div = 3;
    send_frame(0, 8, 2'b10, 0, 8'h4E, 0, 1, 1, 8'h00, 0, "R12_level");
    send_frame(1, 8, 2'b00, 1, 8'hB1, 0, 1, 1, 8'h00, 0, "R12_manch");
    div = 1;

    repeat (20) @(negedge clk);
    check(q.size() == 0, "R11", "frames left", 8'(q.size()), 8'h00);
    done_run = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule